// File: doc/BRIEF.md
# Camera Packet Filter and Demultiplexer

This block sits behind a camera serial receiver. It takes in a stream of 32-bit words that holds packets one after another. It reads the header word of each packet and keeps only the packets on one selected virtual channel. It then sends each kept packet to one of two outputs.

The first output is the video pipe. It carries frame and line markers and payload words that have one chosen data type. These items cross through a gray-coded asynchronous FIFO into a pixel clock, which the downstream consumer supplies. On that side each payload word is split into byte pixels. Between lines the block inserts an idle gap that can be set from 1 to 16 cycles.

The second output is the data pipe. It carries every other kept packet, whole and in order, on a valid/ready port that a DMA engine can drain. When the data pipe applies backpressure, the input is stalled and no word is lost. When the video FIFO fills during a packet, the rest of that packet is dropped and a sticky error flag is raised.

Top module: `cam_pkt_demux`

## Requirements
- R1: A header word carries the data type in bits [5:0], the virtual channel in bits [7:6] and, for long packets, the number of following payload words in bits [23:8]. A data type below 0x10 marks a short packet, which has no payload. Short codes: 0x00 frame start, 0x01 frame end, 0x02 line start, 0x03 line end.
- R2: A packet whose virtual channel differs from `cfg_vc` is discarded together with its payload. It produces nothing on either output.
- R3: With `cfg_video_en` high, on the selected channel, the four marker codes 0x00–0x03 and the long packets whose data type equals `cfg_video_dt` go to the video pipe.
- R4: Every other packet on the selected channel goes to the data pipe, whole, header word first, in arrival order. This includes long packets of other types, short codes 0x04–0x0F and zero-length long packets.
- R5: With `cfg_video_en` low, every packet on the selected channel, markers included, goes to the data pipe.
- R6: While `dp_valid` is high and `dp_ready` is low, `dp_data` and `dp_valid` hold. Input is stalled (`in_ready` low) only when a data-pipe word has no room, and no accepted word is lost.
- R7: Each video payload word leaves as four pixels, least significant byte first. Pixels come on consecutive pixel-clock cycles while the next word is already queued.
- R8: `frame_valid` rises on frame start and falls on frame end. `line_valid` rises on line start or on the first payload word of a line, and falls on line end or frame end. `pix_valid` is high only inside a line and a frame.
- R9: After a line end or frame end, at least `cfg_gap`+1 pixel cycles pass with `pix_valid` low before the next pixel. When a line end is followed directly by already-queued payload, exactly `cfg_gap`+1 cycles pass. The range is 1–16, and field value 15 gives 16.
- R10: When a video item meets a full FIFO, the remaining words of that packet are dropped and `ovf_err` is set. `ovf_err` stays set until reset. Video traffic never stalls the input, and the next packet header resumes normal routing.
- R11: After reset, `in_ready` is 1 and `dp_valid`, `pix_valid`, `line_valid`, `frame_valid` and `ovf_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (input and data-pipe side) |
| rst | input | 1 | Synchronous active-high reset, core domain |
| pix_clk | input | 1 | Pixel clock supplied by the downstream consumer |
| pix_rst | input | 1 | Synchronous active-high reset, pixel domain |
| cfg_video_en | input | 1 | Enables routing to the video pipe |
| cfg_vc | input | 2 | Selected virtual channel |
| cfg_video_dt | input | 6 | Long-packet data type sent to the video pipe |
| cfg_gap | input | GAP_W | Inter-line idle cycles minus one |
| in_data | input | 32 | Incoming packet word |
| in_valid | input | 1 | Incoming word valid |
| in_ready | output | 1 | Block accepts the incoming word |
| dp_data | output | 32 | Data-pipe word |
| dp_valid | output | 1 | Data-pipe word valid |
| dp_ready | input | 1 | Data-pipe consumer ready |
| pix_data | output | PIX_W | Pixel value |
| pix_valid | output | 1 | Pixel qualifier |
| line_valid | output | 1 | Inside a line |
| frame_valid | output | 1 | Inside a frame |
| ovf_err | output | 1 | Sticky video FIFO overflow flag |

## Verification
The routing is tried with packets on a foreign channel, with the video type and a non-video type on the selected channel, with zero-length and reserved short packets, and with the video pipe turned off. This shows that channel filtering, type selection and the disable path are separate decisions. The data pipe is drained under random and steady ready patterns, which shows that backpressure stalls the input without losing or reordering words. Two video frames with gap settings 4 and 16 check the byte order and the exact idle count from a line end to the next queued line. A long burst into a slow pixel clock shows the packet-local drop, the sticky flag and recovery on the next header.

// File: rtl/pkt_demux_pkg.sv
`timescale 1ns/1ps
package pkt_demux_pkg;
  localparam int WORD_W   = 32;
  localparam int DT_LSB   = 0;
  localparam int DT_W     = 6;
  localparam int VC_LSB   = 6;
  localparam int VC_W     = 2;
  localparam int WC_LSB   = 8;
  localparam int WC_W     = 16;
  localparam logic [DT_W-1:0] DT_SHORT_LIMIT = 6'h10;
  localparam logic [DT_W-1:0] DT_MARK_LIMIT  = 6'h04;

  typedef enum logic [2:0] {
    TK_FS   = 3'd0,
    TK_FE   = 3'd1,
    TK_LS   = 3'd2,
    TK_LE   = 3'd3,
    TK_WORD = 3'd4
  } tok_kind_e;

  typedef struct packed {
    tok_kind_e          kind;
    logic [WORD_W-1:0]  word;
  } vtok_t;

  typedef enum logic [1:0] {
    RT_DROP = 2'd0,
    RT_VID  = 2'd1,
    RT_DATA = 2'd2
  } route_e;
endpackage

// File: rtl/pkt_router.sv
`timescale 1ns/1ps
module pkt_router
  import pkt_demux_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_video_en,
  input  logic [VC_W-1:0]    cfg_vc,
  input  logic [DT_W-1:0]    cfg_video_dt,
  input  logic [WORD_W-1:0]  in_data,
  input  logic               in_valid,
  output logic               in_ready,
  output logic [WORD_W-1:0]  dp_data,
  output logic               dp_valid,
  input  logic               dp_ready,
  output logic               vf_wr,
  output vtok_t              vf_wdata,
  input  logic               vf_full,
  output logic               ovf_err
);
  logic [DT_W-1:0] h_dt;
  logic [VC_W-1:0] h_vc;
  logic [WC_W-1:0] h_wc;
  logic            h_short;
  route_e          hdr_rt, cur_rt, word_rt;
  tok_kind_e       short_kind;
  logic            in_pay, drop_q, xfer, want_vid, dp_space;
  logic [WC_W-1:0] remain;

  assign h_dt    = in_data[DT_LSB +: DT_W];
  assign h_vc    = in_data[VC_LSB +: VC_W];
  assign h_wc    = in_data[WC_LSB +: WC_W];
  assign h_short = h_dt < DT_SHORT_LIMIT;

  always_comb begin
    if (h_vc != cfg_vc)
      hdr_rt = RT_DROP;
    else if (cfg_video_en && ((h_short && h_dt < DT_MARK_LIMIT) ||
                              (!h_short && h_dt == cfg_video_dt)))
      hdr_rt = RT_VID;
    else
      hdr_rt = RT_DATA;
  end

  always_comb begin
    case (h_dt[1:0])
      2'd0:    short_kind = TK_FS;
      2'd1:    short_kind = TK_FE;
      2'd2:    short_kind = TK_LS;
      default: short_kind = TK_LE;
    endcase
  end

  assign word_rt  = in_pay ? cur_rt : hdr_rt;
  assign dp_space = !dp_valid || dp_ready;
  assign in_ready = (word_rt == RT_DATA) ? dp_space : 1'b1;
  assign xfer     = in_valid && in_ready;
  assign want_vid = xfer && (word_rt == RT_VID) && (in_pay ? !drop_q : h_short);
  assign vf_wr    = want_vid && !vf_full;

  always_comb begin
    vf_wdata.kind = in_pay ? TK_WORD : short_kind;
    vf_wdata.word = in_data;
  end

  // packet tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      in_pay <= 1'b0;
      remain <= '0;
      cur_rt <= RT_DROP;
      drop_q <= 1'b0;
    end else if (xfer) begin
      if (!in_pay) begin
        drop_q <= 1'b0;
        cur_rt <= hdr_rt;
        remain <= h_wc;
        if (!h_short && h_wc != '0) in_pay <= 1'b1;
      end else begin
        remain <= remain - 1'b1;
        if (remain == WC_W'(1)) in_pay <= 1'b0;
        if (want_vid && vf_full) drop_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ovf_err <= 1'b0;
    else if (want_vid && vf_full) ovf_err <= 1'b1;
  end

  // registered data-pipe output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      dp_valid <= 1'b0;
      dp_data  <= '0;
    end else if (xfer && word_rt == RT_DATA) begin
      dp_valid <= 1'b1;
      dp_data  <= in_data;
    end else if (dp_ready) begin
      dp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gray_async_fifo.sv
`timescale 1ns/1ps
module gray_async_fifo #(
  parameter int W     = 35,
  parameter int DEPTH = 16
) (
  input  logic         wclk,
  input  logic         wrst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         rclk,
  input  logic         rrst,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wbin, wgray, wbin_n, wgray_n, rq1, rq2;
  logic [AW:0]  rbin, rgray, rbin_n, rgray_n, wq1, wq2;

  assign wbin_n  = wbin + {{AW{1'b0}}, (wr && !full)};
  assign wgray_n = wbin_n ^ (wbin_n >> 1);
  assign rbin_n  = rbin + {{AW{1'b0}}, (rd && !empty)};
  assign rgray_n = rbin_n ^ (rbin_n >> 1);

  always_ff @(posedge wclk) begin
    if (wr && !full) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0; full <= 1'b0;
    end else begin
      wbin  <= wbin_n;
      wgray <= wgray_n;
      rq1   <= rgray;
      rq2   <= rq1;
      full  <= (wgray_n == {~rq2[AW:AW-1], rq2[AW-2:0]});
    end
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0; empty <= 1'b1;
    end else begin
      rbin  <= rbin_n;
      rgray <= rgray_n;
      wq1   <= wgray;
      wq2   <= wq1;
      empty <= (rgray_n == wq2);
    end
  end

  assign rdata = mem[rbin[AW-1:0]];
endmodule

// File: rtl/pix_unpacker.sv
`timescale 1ns/1ps
module pix_unpacker
  import pkt_demux_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int GAP_W = 4
) (
  input  logic             pix_clk,
  input  logic             pix_rst,
  input  logic [GAP_W-1:0] cfg_gap,
  input  vtok_t            rd_tok,
  input  logic             rd_empty,
  output logic             rd_en,
  output logic [PIX_W-1:0] pix_data,
  output logic             pix_valid,
  output logic             line_valid,
  output logic             frame_valid
);
  localparam int PPW   = WORD_W / PIX_W;
  localparam int IDX_W = (PPW > 1) ? $clog2(PPW) : 1;

  logic [GAP_W-1:0]  gcnt;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx;
  logic              busy;

  assign rd_en = !rd_empty && (gcnt == '0) && !busy;

  always_ff @(posedge pix_clk) begin
    if (pix_rst) begin
      gcnt <= '0; word_q <= '0; idx <= '0; busy <= 1'b0;
      pix_data <= '0; pix_valid <= 1'b0; line_valid <= 1'b0; frame_valid <= 1'b0;
    end else begin
      pix_valid <= 1'b0;
      if (gcnt != '0) begin
        gcnt <= gcnt - 1'b1;
      end else if (busy) begin
        pix_data  <= word_q[idx*PIX_W +: PIX_W];
        pix_valid <= 1'b1;
        idx       <= idx + 1'b1;
        if (idx == IDX_W'(PPW-1)) busy <= 1'b0;
      end else if (rd_en) begin
        case (rd_tok.kind)
          TK_FS: frame_valid <= 1'b1;
          TK_FE: begin frame_valid <= 1'b0; line_valid <= 1'b0; gcnt <= cfg_gap; end
          TK_LS: line_valid <= 1'b1;
          TK_LE: begin line_valid <= 1'b0; gcnt <= cfg_gap; end
          default: begin
            word_q     <= rd_tok.word;
            pix_data   <= rd_tok.word[PIX_W-1:0];
            pix_valid  <= 1'b1;
            line_valid <= 1'b1;
            idx        <= IDX_W'(1);
            busy       <= (PPW > 1);
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cam_pkt_demux.sv
`timescale 1ns/1ps
module cam_pkt_demux
  import pkt_demux_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int PIX_W      = 8,
  parameter int GAP_W      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_clk,
  input  logic               pix_rst,
  input  logic               cfg_video_en,
  input  logic [1:0]         cfg_vc,
  input  logic [5:0]         cfg_video_dt,
  input  logic [GAP_W-1:0]   cfg_gap,
  input  logic [31:0]        in_data,
  input  logic               in_valid,
  output logic               in_ready,
  output logic [31:0]        dp_data,
  output logic               dp_valid,
  input  logic               dp_ready,
  output logic [PIX_W-1:0]   pix_data,
  output logic               pix_valid,
  output logic               line_valid,
  output logic               frame_valid,
  output logic               ovf_err
);
  localparam int TOK_W = $bits(vtok_t);

  logic             vf_wr, vf_full, vf_rd, vf_empty;
  vtok_t            vf_wdata, vf_rtok;
  logic [TOK_W-1:0] vf_rdata;

  pkt_router u_router (
    .clk(clk), .rst(rst),
    .cfg_video_en(cfg_video_en), .cfg_vc(cfg_vc), .cfg_video_dt(cfg_video_dt),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .dp_data(dp_data), .dp_valid(dp_valid), .dp_ready(dp_ready),
    .vf_wr(vf_wr), .vf_wdata(vf_wdata), .vf_full(vf_full), .ovf_err(ovf_err)
  );

  gray_async_fifo #(.W(TOK_W), .DEPTH(FIFO_DEPTH)) u_cdc_fifo (
    .wclk(clk), .wrst(rst), .wr(vf_wr), .wdata(vf_wdata), .full(vf_full),
    .rclk(pix_clk), .rrst(pix_rst), .rd(vf_rd), .rdata(vf_rdata), .empty(vf_empty)
  );

  assign vf_rtok = vtok_t'(vf_rdata);

  pix_unpacker #(.PIX_W(PIX_W), .GAP_W(GAP_W)) u_unpack (
    .pix_clk(pix_clk), .pix_rst(pix_rst), .cfg_gap(cfg_gap),
    .rd_tok(vf_rtok), .rd_empty(vf_empty), .rd_en(vf_rd),
    .pix_data(pix_data), .pix_valid(pix_valid),
    .line_valid(line_valid), .frame_valid(frame_valid)
  );
endmodule

// File: rtl/cam_pkt_demux_chk.sv
`timescale 1ns/1ps
module cam_pkt_demux_chk #(
  parameter int GAP_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_clk,
  input logic             pix_rst,
  input logic [GAP_W-1:0] cfg_gap,
  input logic             in_ready,
  input logic [31:0]      dp_data,
  input logic             dp_valid,
  input logic             dp_ready,
  input logic             ovf_err,
  input logic             pix_valid,
  input logic             line_valid
);
  logic [GAP_W+1:0] idle_cnt;
  logic             armed, lv_q;

  always_ff @(posedge pix_clk) begin
    if (pix_rst) begin
      idle_cnt <= '0; armed <= 1'b0; lv_q <= 1'b0;
    end else begin
      lv_q <= line_valid;
      if (pix_valid) begin
        idle_cnt <= '0;
        armed    <= 1'b0;
      end else begin
        if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
        if (lv_q && !line_valid) armed <= 1'b1;
      end
    end
  end

  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (dp_valid && !dp_ready) |=> (dp_valid && $stable(dp_data)));

  a_r6_stall_only_on_full: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (dp_valid && !dp_ready));

  a_r10_sticky_ovf: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);

  a_r8_pixel_in_line: assert property (@(posedge pix_clk) disable iff (pix_rst)
    pix_valid |-> line_valid);

  a_r9_min_gap: assert property (@(posedge pix_clk) disable iff (pix_rst)
    (pix_valid && armed) |-> (idle_cnt >= ({2'b00, cfg_gap} + 1'b1)));
endmodule

bind cam_pkt_demux cam_pkt_demux_chk #(.GAP_W(GAP_W)) u_chk (
  .clk(clk), .rst(rst), .pix_clk(pix_clk), .pix_rst(pix_rst),
  .cfg_gap(cfg_gap), .in_ready(in_ready), .dp_data(dp_data),
  .dp_valid(dp_valid), .dp_ready(dp_ready), .ovf_err(ovf_err),
  .pix_valid(pix_valid), .line_valid(line_valid)
);

// File: tb/cam_pkt_demux_tb_top.sv
`timescale 1ns/1ps
module cam_pkt_demux_tb_top;
  logic clk = 1'b0, pix_clk = 1'b0, rst = 1'b1, pix_rst = 1'b1;
  logic cfg_video_en = 1'b0;
  logic [1:0] cfg_vc = 2'd0;
  logic [5:0] cfg_video_dt = 6'h2A;
  logic [3:0] cfg_gap = 4'd15;
  logic [31:0] in_data = '0;
  logic in_valid = 1'b0, dp_ready = 1'b1;
  logic in_ready, dp_valid, pix_valid, line_valid, frame_valid, ovf_err;
  logic [31:0] dp_data;
  logic [7:0] pix_data;

  always #2 clk = ~clk;
  initial begin #1; forever #5 pix_clk = ~pix_clk; end

  cam_pkt_demux dut_i (
    .clk(clk), .rst(rst), .pix_clk(pix_clk), .pix_rst(pix_rst),
    .cfg_video_en(cfg_video_en), .cfg_vc(cfg_vc), .cfg_video_dt(cfg_video_dt),
    .cfg_gap(cfg_gap), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .dp_data(dp_data), .dp_valid(dp_valid), .dp_ready(dp_ready),
    .pix_data(pix_data), .pix_valid(pix_valid), .line_valid(line_valid),
    .frame_valid(frame_valid), .ovf_err(ovf_err)
  );

  typedef struct { logic [7:0] d; int idle; } pexp_t;
  pexp_t       pq[$];
  logic [31:0] dq[$];
  int checks = 0, errors = 0;
  int dp_mode = 0;
  int last_tok = 0;
  int pidle = 0, px_cnt = 0, dp_cnt = 0;
  bit mon_en = 0, pix_ignore = 0, done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // data-pipe ready pattern, changed away from the sampling edge
  always @(posedge clk) begin
    #1;
    case (dp_mode)
      0: dp_ready <= 1'b1;
      1: dp_ready <= ($urandom % 3) != 0;
      default: dp_ready <= 1'b0;
    endcase
  end

  // data-pipe monitor
  always @(negedge clk) if (mon_en && dp_valid && dp_ready) begin
    dp_cnt++;
    if (dq.size() == 0) check(0, "R2/R4 unexpected data-pipe word", dp_data, 0);
    else begin
      logic [31:0] e;
      e = dq.pop_front();
      check(dp_data == e, "R4 data-pipe word", dp_data, e);
    end
  end

  // pixel monitor
  always @(negedge pix_clk) if (mon_en) begin
    if (pix_valid) begin
      px_cnt++;
      if (!pix_ignore) begin
        if (pq.size() == 0) check(0, "R2/R7 unexpected pixel", pix_data, 0);
        else begin
          pexp_t e;
          e = pq.pop_front();
          check(pix_data == e.d, "R7 pixel value", pix_data, e.d);
          check(line_valid && frame_valid, "R8 framing during pixel",
                {line_valid, frame_valid}, 2'b11);
          if (e.idle >= 0) check(pidle == e.idle, "R9 idle cycles before pixel", pidle, e.idle);
        end
      end
      pidle = 0;
    end else pidle++;
  end

  task automatic put_word(input logic [31:0] w);
    @(negedge clk);
    in_data = w; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic idle_in();
    @(negedge clk); in_valid = 1'b0;
  endtask

  function automatic logic [31:0] pay(input logic [31:0] seed, input int i);
    return seed + i * 32'h1357_9BDF;
  endfunction

  task automatic send_long(input logic [1:0] vc, input logic [5:0] dt, input int nw,
                           input logic [31:0] seed);
    logic [31:0] h;
    bit sel, vid;
    h = {8'h00, nw[15:0], vc, dt};
    sel = (vc == cfg_vc);
    vid = sel && cfg_video_en && (dt == cfg_video_dt);
    if (sel && !vid) begin
      dq.push_back(h);
      for (int i = 0; i < nw; i++) dq.push_back(pay(seed, i));
    end
    if (vid) begin
      for (int i = 0; i < nw; i++) begin
        logic [31:0] w;
        w = pay(seed, i);
        for (int b = 0; b < 4; b++) begin
          pexp_t e;
          e.d = w[8*b +: 8];
          e.idle = (b != 0) ? 0 : (last_tok == 1) ? 0 : (last_tok == 2) ? int'(cfg_gap) + 1 : -1;
          pq.push_back(e);
        end
        last_tok = 1;
      end
    end else last_tok = 0;
    put_word(h);
    for (int i = 0; i < nw; i++) put_word(pay(seed, i));
    idle_in();
  endtask

  task automatic send_short(input logic [1:0] vc, input logic [5:0] code);
    logic [31:0] h;
    h = {24'h0, vc, code};
    if (vc == cfg_vc) begin
      if (cfg_video_en && code < 6'h04) last_tok = (code == 6'h03) ? 2 : 0;
      else begin dq.push_back(h); last_tok = 0; end
    end else last_tok = 0;
    put_word(h);
    idle_in();
  endtask

  task automatic wait_drain();
    int n = 0;
    while ((pq.size() != 0 || dq.size() != 0) && n < 20000) begin @(negedge clk); n++; end
    repeat (60) @(negedge pix_clk);
  endtask

  initial begin
    #600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (6) @(posedge pix_clk);
    @(negedge clk); rst = 1'b0;
    @(negedge pix_clk); pix_rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(in_ready == 1'b1, "R11 in_ready after reset", in_ready, 1);
    check(dp_valid == 1'b0, "R11 dp_valid after reset", dp_valid, 0);
    check(pix_valid == 1'b0, "R11 pix_valid after reset", pix_valid, 0);
    check(line_valid == 1'b0 && frame_valid == 1'b0, "R11 framing after reset",
          {line_valid, frame_valid}, 0);
    check(ovf_err == 1'b0, "R11 ovf_err after reset", ovf_err, 0);
    mon_en = 1;

    // R1 R3 R7 R8 R9: video frame on channel 1, gap 4
    cfg_vc = 2'd1; cfg_video_dt = 6'h2A; cfg_video_en = 1'b1; cfg_gap = 4'd3;
    send_short(2'd1, 6'h00);
    send_short(2'd1, 6'h02);
    send_long(2'd1, 6'h2A, 3, 32'hA1B2_C3D4);
    send_short(2'd1, 6'h03);
    send_long(2'd1, 6'h2A, 2, 32'h0102_0304);
    send_short(2'd1, 6'h03);
    send_short(2'd1, 6'h01);
    wait_drain();
    check(frame_valid == 1'b0 && line_valid == 1'b0, "R8 framing closed after frame end",
          {line_valid, frame_valid}, 0);

    // R4 R6: data pipe under random ready
    dp_mode = 1;
    send_long(2'd1, 6'h12, 5, 32'h5555_0000);
    send_short(2'd1, 6'h08);
    send_long(2'd1, 6'h30, 0, 32'h0);
    send_long(2'd1, 6'h2B, 3, 32'h7777_1111);
    dp_mode = 2;
    send_long(2'd1, 6'h13, 0, 32'h0);
    repeat (3) @(negedge clk);
    @(negedge clk); in_data = {24'h0, 2'd1, 6'h09}; in_valid = 1'b1; #1;
    check(in_ready == 1'b0, "R6 input stalled while data pipe full", in_ready, 0);
    check(dp_valid == 1'b1, "R6 dp_valid held while not ready", dp_valid, 1);
    in_valid = 1'b0;
    dp_mode = 1;
    wait_drain();
    dp_mode = 0;

    // R2: foreign channel, payload resembling headers
    begin
      int d0, p0;
      d0 = dp_cnt; p0 = px_cnt;
      send_long(2'd2, 6'h2A, 3, {24'h0, 2'd1, 6'h00});
      send_long(2'd3, 6'h12, 2, {8'h0, 16'h0001, 2'd1, 6'h12});
      send_short(2'd0, 6'h00);
      repeat (200) @(negedge clk);
      check(dp_cnt == d0, "R2 no data-pipe output for foreign channel", dp_cnt - d0, 0);
      check(px_cnt == p0, "R2 no pixel output for foreign channel", px_cnt - p0, 0);
      send_long(2'd1, 6'h14, 1, 32'hCAFE_F00D);
      wait_drain();
    end

    // R5: video disabled, everything on the channel goes to the data pipe
    cfg_video_en = 1'b0;
    begin
      int p0;
      p0 = px_cnt;
      send_short(2'd1, 6'h00);
      send_long(2'd1, 6'h2A, 2, 32'h1111_2222);
      send_short(2'd1, 6'h01);
      wait_drain();
      check(px_cnt == p0, "R5 no pixels while video disabled", px_cnt - p0, 0);
    end

    // R9 R3 R4: gap 16, a data packet inside a video line
    cfg_video_en = 1'b1; cfg_gap = 4'd15;
    send_short(2'd1, 6'h00);
    send_long(2'd1, 6'h2A, 2, 32'hDEAD_BEEF);
    send_short(2'd1, 6'h03);
    send_long(2'd1, 6'h2A, 2, 32'h0BAD_F00D);
    send_long(2'd1, 6'h21, 2, 32'h3333_4444);
    send_long(2'd1, 6'h2A, 1, 32'h9988_7766);
    send_short(2'd1, 6'h03);
    send_short(2'd1, 6'h01);
    wait_drain();

    // R10: overflow into the slow pixel clock
    begin
      realtime t0, t1;
      int p0;
      check(ovf_err == 1'b0, "R10 flag clear before overflow", ovf_err, 0);
      pix_ignore = 1;
      send_short(2'd1, 6'h00);
      p0 = px_cnt;
      t0 = $realtime;
      put_word({8'h0, 16'd40, 2'd1, 6'h2A});
      for (int i = 0; i < 40; i++) put_word(pay(32'h4242_0000, i));
      t1 = $realtime;
      idle_in();
      check((t1 - t0) <= 42 * 4, "R10 video overflow does not stall input",
            longint'((t1 - t0) / 4), 41);
      @(negedge clk);
      check(ovf_err == 1'b1, "R10 flag set on overflow", ovf_err, 1);
      repeat (500) @(negedge pix_clk);
      check(px_cnt - p0 < 160, "R10 rest of packet dropped", px_cnt - p0, 159);
      pq.delete();
      pix_ignore = 0;
      last_tok = 0;
      send_short(2'd1, 6'h03);
      send_short(2'd1, 6'h01);
      repeat (100) @(negedge pix_clk);
      send_short(2'd1, 6'h00);
      send_short(2'd1, 6'h02);
      send_long(2'd1, 6'h2A, 2, 32'hFEED_0123);
      send_short(2'd1, 6'h03);
      send_short(2'd1, 6'h01);
      wait_drain();
      check(ovf_err == 1'b1, "R10 flag stays set", ovf_err, 1);
    end

    check(pq.size() == 0, "R7 all expected pixels seen", pq.size(), 0);
    check(dq.size() == 0, "R4 all expected data words seen", dq.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule